// File: doc/BRIEF.md
# Cache Line Range Maintenance Engine

This block sequences cache maintenance over address ranges, one line at a time. Software first writes a start address, then writes an end address together with the operation kind (clean or invalidate). The end write arms a hardware walk. The walk visits, in ascending order, every 32-byte line whose first byte lies inside the inclusive window between the two addresses. For each visited line the engine sends a command to the tag/state array over a valid/ready handshake.

The requester is held off for the whole walk. `busy` is high and `wr_ready` is low until a one-cycle `done` pulse marks completion. The start address is the only address that is translated, so a window whose end falls in a different 4 KiB page is refused: no command is issued and `err` is raised.

The same command path also carries three single-line operations (clean, clean+invalidate, invalidate) and a whole-cache invalidate.

Top module: `line_maint_engine`

## Requirements
- R1: The line address of a byte address is that address with its low 5 bits cleared, and every `lc_addr` issued has its low 5 bits at zero.
- R2: A write of kind 0 (set start) only stores the start address. The engine stays idle (`busy` low) and issues no command. A second kind-0 write replaces the stored start.
- R3: A write of kind 1 (range clean) or kind 2 (range invalidate) carries the end address and starts the walk. The walk issues one command per line whose first byte address lies in [start, end], both ends included, in ascending address order. The command op is 0 (clean) for kind 1 and 2 (invalidate) for kind 2.
- R4: From the cycle after a range, line or invalidate-all write is accepted until the end of its `done` cycle, `busy` is high and `wr_ready` is low, so further writes are held back.
- R5: The line walk advances only on an accepted command (`lc_valid` and `lc_ready` both high). While `lc_ready` is low, `lc_valid`, `lc_addr` and `lc_op` hold their values.
- R6: `done` is high for exactly one cycle: the cycle after the last command is accepted. `busy` is still high in that cycle and low in the next.
- R7: If the window holds no line start (end below start, or no 32-byte boundary inside the window), no command is issued. `done` rises in the first cycle after the end write is accepted, and `err` is low.
- R8: If the end address differs from the start address in any bit above bit 11, the operation is refused. No command is issued, `done` rises in the first cycle after acceptance, and `err` is high from that cycle until the next write of kind 1 to 6 is accepted.
- R9: A write of kind 3, 4 or 5 issues exactly one command at the line address of `wr_data`, with op 0 (clean), 1 (clean+invalidate) or 2 (invalidate) respectively.
- R10: A write of kind 6 (invalidate all) issues exactly one command with op 3 and address 0.
- R11: During and right after reset, `busy`, `done`, `err` and `lc_valid` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_kind | input | 3 | Write kind: 0 set start, 1 range clean, 2 range invalidate, 3 line clean, 4 line clean+invalidate, 5 line invalidate, 6 invalidate all |
| wr_data | input | ADDR_W | Address carried by the write |
| lc_valid | output | 1 | Per-line command valid |
| lc_ready | input | 1 | Per-line command accepted / acknowledged |
| lc_op | output | 2 | Command op: 0 clean, 1 clean+invalidate, 2 invalidate, 3 invalidate all |
| lc_addr | output | ADDR_W | Line address of the command |
| busy | output | 1 | Operation in progress, requester stalled |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was refused for crossing a page |

## Verification
The bench sweeps start and end offsets inside one page and computes the expected number of lines, the first line and the refusal bit arithmetically. The sweep covers unaligned starts that round up past the end, ends one byte before a line start, and windows that fill the whole page. A design that rounds the start down, or that treats the end as exclusive, issues one line too many or one too few, and the count and address checks catch it.

Refused windows, including an end below the start in the previous page, are checked to produce no commands, a done pulse in the next cycle and a flag that persists until the next operation. The sweep is repeated with `lc_ready` always high, alternating, and pseudo-random. A walker that advances without a handshake skips addresses, and one that drops `busy` early shows `wr_ready` high while commands are still pending.

// File: rtl/lme_pkg.sv
package lme_pkg;

    typedef enum logic [2:0] {
        K_SET_START      = 3'd0,
        K_END_CLEAN      = 3'd1,
        K_END_INV        = 3'd2,
        K_LINE_CLEAN     = 3'd3,
        K_LINE_CLEAN_INV = 3'd4,
        K_LINE_INV       = 3'd5,
        K_INV_ALL        = 3'd6,
        K_RSVD           = 3'd7
    } wr_kind_e;

    typedef enum logic [1:0] {
        OP_CLEAN     = 2'd0,
        OP_CLEAN_INV = 2'd1,
        OP_INV       = 2'd2,
        OP_INV_ALL   = 2'd3
    } line_op_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_WALK = 2'd1,
        W_FIN  = 2'd2
    } walk_state_e;

    function automatic line_op_e kind_to_op(input wr_kind_e k);
        case (k)
            K_END_CLEAN, K_LINE_CLEAN: return OP_CLEAN;
            K_LINE_CLEAN_INV:          return OP_CLEAN_INV;
            K_END_INV, K_LINE_INV:     return OP_INV;
            default:                   return OP_INV_ALL;
        endcase
    endfunction

    function automatic logic kind_launches(input wr_kind_e k);
        return (k != K_SET_START) && (k != K_RSVD);
    endfunction

endpackage

// File: rtl/lme_front.sv
module lme_front
    import lme_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 5,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  wr_kind_e          wr_kind,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              launch,
    output line_op_e          l_op,
    output logic [ADDR_W-1:0] l_first,
    output logic [ADDR_W-1:0] l_last,
    output logic              l_skip,
    output logic              l_reject
);

    localparam int unsigned ROUND_UP = (1 << LINE_W) - 1;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W:0]   first_x;
    logic [ADDR_W-1:0] data_line;
    logic              same_page;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_fire && wr_kind == K_SET_START) begin
            start_q <= wr_data;
        end
    end

    always_comb begin
        first_x = {1'b0, start_q} + (ADDR_W+1)'(ROUND_UP);
        first_x[LINE_W-1:0] = '0;
        data_line = {wr_data[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
        same_page = (start_q[ADDR_W-1:PAGE_W] == wr_data[ADDR_W-1:PAGE_W]);
    end

    always_comb begin
        launch   = wr_fire && kind_launches(wr_kind);
        l_op     = kind_to_op(wr_kind);
        l_first  = '0;
        l_last   = '0;
        l_skip   = 1'b0;
        l_reject = 1'b0;
        case (wr_kind)
            K_END_CLEAN, K_END_INV: begin
                l_first  = first_x[ADDR_W-1:0];
                l_last   = data_line;
                l_reject = !same_page;
                l_skip   = !same_page || (first_x > {1'b0, data_line});
            end
            K_LINE_CLEAN, K_LINE_CLEAN_INV, K_LINE_INV: begin
                l_first = data_line;
                l_last  = data_line;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/lme_walker.sv
module lme_walker
    import lme_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  line_op_e          l_op,
    input  logic [ADDR_W-1:0] l_first,
    input  logic [ADDR_W-1:0] l_last,
    input  logic              l_skip,
    input  logic              l_reject,
    input  logic              lc_ready,
    output logic              idle,
    output logic              lc_valid,
    output line_op_e          lc_op,
    output logic [ADDR_W-1:0] lc_addr,
    output logic              done,
    output logic              err
);

    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(1) << LINE_W;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] last_q;
    line_op_e          op_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            cur_q   <= '0;
            last_q  <= '0;
            op_q    <= OP_CLEAN;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (launch) begin
                        op_q    <= l_op;
                        cur_q   <= l_first;
                        last_q  <= l_last;
                        err_q   <= l_reject;
                        state_q <= l_skip ? W_FIN : W_WALK;
                    end
                end
                W_WALK: begin
                    if (lc_ready) begin
                        if (cur_q == last_q) begin
                            state_q <= W_FIN;
                        end else begin
                            cur_q <= cur_q + LINE_STEP;
                        end
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (state_q == W_IDLE);
        lc_valid = (state_q == W_WALK);
        done     = (state_q == W_FIN);
        lc_op    = op_q;
        lc_addr  = cur_q;
        err      = err_q;
    end

endmodule

// File: rtl/line_maint_engine.sv
module line_maint_engine
    import lme_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 5,
    parameter int PAGE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [2:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              lc_valid,
    input  logic              lc_ready,
    output logic [1:0]        lc_op,
    output logic [ADDR_W-1:0] lc_addr,
    output logic              busy,
    output logic              done,
    output logic              err
);

    logic              idle;
    logic              wr_fire;
    logic              launch;
    line_op_e          l_op;
    line_op_e          cmd_op;
    logic [ADDR_W-1:0] l_first;
    logic [ADDR_W-1:0] l_last;
    logic              l_skip;
    logic              l_reject;

    assign wr_fire  = wr_valid && idle;
    assign wr_ready = idle;
    assign busy     = !idle;
    assign lc_op    = cmd_op;

    lme_front #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .PAGE_W (PAGE_W)
    ) front_i (
        .clk      (clk),
        .rst      (rst),
        .wr_fire  (wr_fire),
        .wr_kind  (wr_kind_e'(wr_kind)),
        .wr_data  (wr_data),
        .launch   (launch),
        .l_op     (l_op),
        .l_first  (l_first),
        .l_last   (l_last),
        .l_skip   (l_skip),
        .l_reject (l_reject)
    );

    lme_walker #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) walker_i (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .l_op     (l_op),
        .l_first  (l_first),
        .l_last   (l_last),
        .l_skip   (l_skip),
        .l_reject (l_reject),
        .lc_ready (lc_ready),
        .idle     (idle),
        .lc_valid (lc_valid),
        .lc_op    (cmd_op),
        .lc_addr  (lc_addr),
        .done     (done),
        .err      (err)
    );

endmodule

// File: rtl/lme_checker.sv
module lme_checker #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [2:0]        wr_kind,
    input logic              lc_valid,
    input logic              lc_ready,
    input logic [1:0]        lc_op,
    input logic [ADDR_W-1:0] lc_addr,
    input logic              busy,
    input logic              done,
    input logic              err
);

    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        lc_valid |-> (lc_addr[LINE_W-1:0] == '0));

    p_start_only_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_kind == 3'd0) |=> !busy);

    p_cmd_stalls_req_r4: assert property (@(posedge clk) disable iff (rst)
        lc_valid |-> (busy && !wr_ready));

    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (lc_valid && !lc_ready) |=> (lc_valid && $stable(lc_addr) && $stable(lc_op)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

endmodule

bind line_maint_engine lme_checker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_kind  (wr_kind),
    .lc_valid (lc_valid),
    .lc_ready (lc_ready),
    .lc_op    (lc_op),
    .lc_addr  (lc_addr),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/line_maint_engine_tb_top.sv
`timescale 1ns/1ps
module line_maint_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [2:0]  wr_kind = 3'd0;
    logic [31:0] wr_data = '0;
    logic        lc_valid;
    logic        lc_ready = 1'b1;
    logic [1:0]  lc_op;
    logic [31:0] lc_addr;
    logic        busy;
    logic        done;
    logic        err;

    int n_chk = 0;
    int n_fail = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    logic [31:0] mon_addr [0:255];
    logic [1:0]  mon_op   [0:255];
    int mon_cnt = 0;
    int bp_viol = 0;
    int hold_viol = 0;
    int align_viol = 0;
    int ncyc = 0;
    int last_acc_cyc = 0;
    int done_cyc = 0;
    int wd_cyc = 0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [1:0]  prev_op = '0;

    always #5 clk = ~clk;

    line_maint_engine dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_kind  (wr_kind),
        .wr_data  (wr_data),
        .lc_valid (lc_valid),
        .lc_ready (lc_ready),
        .lc_op    (lc_op),
        .lc_addr  (lc_addr),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: lc_ready = 1'b1;
            1: lc_ready = ~lc_ready;
            default: begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                lc_ready = lfsr[0];
            end
        endcase
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall && !(lc_valid && lc_addr == prev_addr && lc_op == prev_op))
                hold_viol++;
            if (lc_valid && (!busy || wr_ready)) bp_viol++;
            if (lc_valid && lc_addr[4:0] != 5'd0) align_viol++;
            if (lc_valid && lc_ready) begin
                if (mon_cnt < 256) begin
                    mon_addr[mon_cnt] = lc_addr;
                    mon_op[mon_cnt] = lc_op;
                end
                mon_cnt++;
                last_acc_cyc = ncyc;
            end
            if (done) done_cyc = ncyc;
            prev_stall = lc_valid && !lc_ready;
            prev_addr = lc_addr;
            prev_op = lc_op;
        end
        ncyc++;
    end

    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc >= 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", wd_cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive_write(input logic [2:0] kind, input logic [31:0] data);
        @(posedge clk);
        #1;
        wr_valid = 1'b1;
        wr_kind = kind;
        wr_data = data;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] kind, input logic [31:0] data,
                          input int exp_op, input longint exp_first, input int exp_n,
                          input bit exp_err, input string tag);
        int mism;
        mon_cnt = 0;
        bp_viol = 0;
        hold_viol = 0;
        align_viol = 0;
        drive_write(kind, data);
        @(negedge clk);
        if (exp_n == 0)
            chk(done == 1'b1, tag, "done in first cycle after empty/refused op", done, 1);
        while (!done) @(negedge clk);
        chk(busy == 1'b1, "R6", "busy in done cycle", busy, 1);
        chk(err == exp_err, tag, "err at done", err, exp_err);
        chk(mon_cnt == exp_n, tag, "line count", mon_cnt, exp_n);
        mism = 0;
        for (int i = 0; i < exp_n && i < 256; i++) begin
            if (mon_addr[i] != 32'(exp_first + 32 * i) || mon_op[i] != 2'(exp_op)) begin
                if (mism == 0)
                    $display("FAIL %s line %0d: actual addr 0x%0h op %0d expected addr 0x%0h op %0d",
                             tag, i, mon_addr[i], mon_op[i], exp_first + 32 * i, exp_op);
                mism++;
            end
        end
        chk(mism == 0, tag, "address/op sequence mismatches", mism, 0);
        chk(bp_viol == 0, "R4", "cycles with command but requester not stalled", bp_viol, 0);
        chk(hold_viol == 0, "R5", "command changed while stalled", hold_viol, 0);
        chk(align_viol == 0, "R1", "unaligned command address", align_viol, 0);
        @(negedge clk);
        chk(!done && !busy, "R6", "done/busy after done cycle", {done, busy}, 0);
        if (exp_n > 0)
            chk(done_cyc == last_acc_cyc + 1, "R6", "done cycle vs last accept",
                done_cyc - last_acc_cyc, 1);
    endtask

    initial begin
        longint s, e, first, last;
        int n;
        bit rej;
        string tag;
        logic [2:0] kind;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !err && !lc_valid && wr_ready, "R11", "reset outputs",
            {busy, done, err, lc_valid, wr_ready}, 5'b00001);
        #1 rst = 1'b0;

        mon_cnt = 0;
        drive_write(3'd0, 32'h2000);
        repeat (4) @(negedge clk);
        chk(!busy && mon_cnt == 0, "R2", "start write left engine active", {busy, 8'(mon_cnt)}, 0);
        drive_write(3'd0, 32'h3000);
        run_op(3'd1, 32'h3040, 0, 64'h3000, 3, 1'b0, "R2");

        for (int m = 0; m < 3; m++) begin
            rdy_mode = m;
            foreach (s_offs[a]) begin
                foreach (e_offs[b]) begin
                    s = 64'h5000 + s_offs[a];
                    e = 64'h5000 + e_offs[b];
                    first = ((s + 31) / 32) * 32;
                    last = (e / 32) * 32;
                    rej = (s / 4096) != (e / 4096);
                    n = rej ? 0 : ((first <= last) ? int'((last - first) / 32 + 1) : 0);
                    tag = rej ? "R8" : ((n == 0) ? "R7" : "R3");
                    kind = ((a + b) % 2 == 0) ? 3'd1 : 3'd2;
                    drive_write(3'd0, 32'(s));
                    run_op(kind, 32'(e), (kind == 3'd1) ? 0 : 2, first, n, 1'b0, tag);
                end
            end
        end

        rdy_mode = 2;
        drive_write(3'd0, 32'h5F00);
        run_op(3'd2, 32'h6000, 2, 0, 0, 1'b1, "R8");
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R8", "err held while idle", err, 1);
        drive_write(3'd0, 32'h5000);
        run_op(3'd1, 32'h4FFF, 0, 0, 0, 1'b1, "R8");
        run_op(3'd3, 32'h1234_567F, 0, 64'h1234_5660, 1, 1'b0, "R9/R1");
        chk(err == 1'b0, "R8", "err cleared by next operation", err, 0);
        run_op(3'd4, 32'h0000_8020, 1, 64'h0000_8020, 1, 1'b0, "R9");
        rdy_mode = 1;
        run_op(3'd5, 32'hFFFF_FFFF, 2, 64'hFFFF_FFE0, 1, 1'b0, "R9");
        run_op(3'd6, 32'h0000_1234, 3, 0, 1, 1'b0, "R10");
        drive_write(3'd0, 32'h7010);
        run_op(3'd1, 32'h7010, 0, 0, 0, 1'b0, "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int s_offs [9] = '{0, 1, 31, 32, 33, 200, 4064, 4065, 4095};
    int e_offs [9] = '{0, 31, 32, 63, 64, 255, 1000, 4064, 4095};

endmodule